// File: doc/BRIEF.md
# Table-Driven Coefficient Quantizer

The block takes the stream of transform coefficients of an image block, one signed sample per clock, and divides each one by a step size taken from a 64-entry table. The sample's place inside the block selects the entry. The quotient is rounded to the nearest integer, and exact halves go away from zero. A host fills the table through a plain write port before it sends any coefficients. An in-block position counter walks the table. A start flag on the first sample of each block returns the counter to entry 0.

Division is a restoring divider with one register stage per quotient bit. It takes one sample on every clock and returns one result on every clock, after a fixed delay. The valid flag and the block-start flag travel down the pipe next to the data. The output stream is therefore the input stream shifted by that delay. A table write is accepted only at a block boundary with no sample on the input. The host cannot change a step size halfway through a block.

Top module: `coef_quant`

## Requirements
- R1: A write with `tbl_wr_en` high stores the 8-bit unsigned `tbl_wr_data` at entry `tbl_wr_addr` when it is accepted. Samples taken after that use the new value at that entry.
- R2: For an input `x` and step `q`, `out_coef` equals `x/q` rounded to the nearest integer. Exact halves round away from zero, so 5/2 gives 3 and -5/2 gives -3. A zero input gives zero, and a result is never of the opposite sign to its input.
- R3: A valid sample with `in_start` high uses entry 0. Each following valid sample uses the next entry. After entry 63 the counter wraps to entry 0 even if no start flag arrives, and a start flag in the middle of a block restarts at entry 0.
- R4: A table entry that holds 0 acts as a step of 1, so the sample passes through unchanged.
- R5: `out_valid` is high exactly 14 clock edges after the edge that sampled a valid input, and at no other time. Cycles with `in_valid` low do not advance the position counter.
- R6: `out_start` is high exactly when the result of a sample that carried `in_start` leaves the block, and only together with `out_valid`.
- R7: A table write is ignored when `in_valid` is high in the same cycle. It is also ignored while the position counter is not at entry 0, that is, in the middle of a block.
- R8: After a synchronous reset, `out_valid` and `out_start` are low and the position counter is at entry 0. A first sample without a start flag therefore uses entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr_en | input | 1 | Table write request |
| tbl_wr_addr | input | 6 | Table entry to write |
| tbl_wr_data | input | 8 | Step size, unsigned |
| in_valid | input | 1 | Input sample present |
| in_start | input | 1 | Sample is the first of a block |
| in_coef | input | 12 | Signed input coefficient |
| out_valid | output | 1 | Result present |
| out_start | output | 1 | Result belongs to the first sample of a block |
| out_coef | output | 12 | Signed quantized result |

## Verification
The bench runs every one of the 4096 input codes through the block and places a step of 1 under the most negative code. A divider that dropped the carry of the magnitude would turn -2048 into 0 or +2048. Entry 5 holds zero: a design that did not force it to 1 would give all-ones or garbage there. Halves are hit at each even step, so truncating or rounding toward zero would be off by one on those samples. Further runs skip the start flag across 130 samples, restart mid-block, and leave bubbles mid-block. A counter that failed to wrap or that advanced on idle cycles would then pick the wrong step. The bench also tries writes while a sample is present and in the middle of a block. A design that accepted them would divide later samples by the new step.

// File: rtl/quant_pkg.sv
package quant_pkg;
   localparam int unsigned QP_ADDR_W = 6;
   localparam int unsigned QP_DEPTH  = 1 << QP_ADDR_W;
   typedef logic [QP_ADDR_W-1:0] qp_addr_t;
endpackage

// File: rtl/quant_pos_ctr.sv
module quant_pos_ctr
   import quant_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     smp_vld,
   input  logic     smp_start,
   output qp_addr_t cur_idx,
   output logic     at_boundary
);
   qp_addr_t nxt_q;

   assign cur_idx     = smp_start ? '0 : nxt_q;
   assign at_boundary = (nxt_q == '0);

   always_ff @(posedge clk) begin
      if (rst)          nxt_q <= '0;
      else if (smp_vld) nxt_q <= cur_idx + qp_addr_t'(1);
   end
endmodule

// File: rtl/quant_table.sv
module quant_table #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/quant_div_stage.sv
module quant_div_stage #(
   parameter int unsigned NUM_W = 13,
   parameter int unsigned REM_W = 10,
   parameter int unsigned BIT   = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             i_vld,
   input  logic             i_st,
   input  logic             i_neg,
   input  logic [NUM_W-1:0] i_num,
   input  logic [REM_W-1:0] i_den,
   input  logic [REM_W-1:0] i_rem,
   input  logic [NUM_W-1:0] i_quo,
   output logic             o_vld,
   output logic             o_st,
   output logic             o_neg,
   output logic [NUM_W-1:0] o_num,
   output logic [REM_W-1:0] o_den,
   output logic [REM_W-1:0] o_rem,
   output logic [NUM_W-1:0] o_quo
);
   logic [REM_W-1:0] rem_sh;
   logic             fits;

   always_comb begin
      rem_sh = {i_rem[REM_W-2:0], i_num[NUM_W-1-BIT]};
      fits   = (rem_sh >= i_den);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         o_vld <= 1'b0;
         o_st  <= 1'b0;
      end else begin
         o_vld <= i_vld;
         o_st  <= i_st;
      end
   end

   always_ff @(posedge clk) begin
      o_neg <= i_neg;
      o_num <= i_num;
      o_den <= i_den;
      o_rem <= fits ? (rem_sh - i_den) : rem_sh;
      o_quo <= {i_quo[NUM_W-2:0], fits};
   end
endmodule

// File: rtl/coef_quant.sv
module coef_quant
   import quant_pkg::*;
#(
   parameter int unsigned COEF_W = 12,
   parameter int unsigned Q_W    = 8,
   localparam int unsigned NUM_W = COEF_W + 1,
   localparam int unsigned REM_W = Q_W + 2,
   localparam int unsigned LAT   = NUM_W + 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 tbl_wr_en,
   input  logic [QP_ADDR_W-1:0] tbl_wr_addr,
   input  logic [Q_W-1:0]       tbl_wr_data,
   input  logic                 in_valid,
   input  logic                 in_start,
   input  logic [COEF_W-1:0]    in_coef,
   output logic                 out_valid,
   output logic                 out_start,
   output logic [COEF_W-1:0]    out_coef
);
   generate
      if (Q_W > COEF_W) begin : g_bad_qw
         $error("coef_quant: Q_W must not exceed COEF_W");
      end
      if (COEF_W < 4) begin : g_bad_cw
         $error("coef_quant: COEF_W must be at least 4");
      end
   endgenerate

   qp_addr_t   cur_idx;
   logic       at_boundary;
   logic [Q_W-1:0] q_raw;
   logic       wr_ok;

   assign wr_ok = tbl_wr_en && !in_valid && at_boundary;

   quant_pos_ctr u_pos (
      .clk(clk), .rst(rst), .smp_vld(in_valid), .smp_start(in_start),
      .cur_idx(cur_idx), .at_boundary(at_boundary)
   );

   quant_table #(.ADDR_W(QP_ADDR_W), .DATA_W(Q_W)) u_tbl (
      .clk(clk), .we(wr_ok), .waddr(tbl_wr_addr), .wdata(tbl_wr_data),
      .raddr(cur_idx), .rdata(q_raw)
   );

   // operand preparation: numerator 2|x|+q, divisor 2q -> floor gives round-half-away
   logic [Q_W-1:0]    q_eff;
   logic [COEF_W-1:0] mag;
   always_comb begin
      q_eff = (q_raw == '0) ? Q_W'(1) : q_raw;
      mag   = in_coef[COEF_W-1] ? (~in_coef + COEF_W'(1)) : in_coef;
   end

   logic             p_vld [NUM_W+1];
   logic             p_st  [NUM_W+1];
   logic             p_neg [NUM_W+1];
   logic [NUM_W-1:0] p_num [NUM_W+1];
   logic [REM_W-1:0] p_den [NUM_W+1];
   logic [REM_W-1:0] p_rem [NUM_W+1];
   logic [NUM_W-1:0] p_quo [NUM_W+1];

   always_ff @(posedge clk) begin
      if (rst) begin
         p_vld[0] <= 1'b0;
         p_st[0]  <= 1'b0;
      end else begin
         p_vld[0] <= in_valid;
         p_st[0]  <= in_valid && in_start;
      end
   end

   always_ff @(posedge clk) begin
      p_neg[0] <= in_coef[COEF_W-1];
      p_num[0] <= {mag, 1'b0} + NUM_W'(q_eff);
      p_den[0] <= {1'b0, q_eff, 1'b0};
      p_rem[0] <= '0;
      p_quo[0] <= '0;
   end

   generate
      for (genvar s = 0; s < NUM_W; s++) begin : g_stage
         quant_div_stage #(.NUM_W(NUM_W), .REM_W(REM_W), .BIT(s)) u_stg (
            .clk(clk), .rst(rst),
            .i_vld(p_vld[s]), .i_st(p_st[s]), .i_neg(p_neg[s]),
            .i_num(p_num[s]), .i_den(p_den[s]), .i_rem(p_rem[s]), .i_quo(p_quo[s]),
            .o_vld(p_vld[s+1]), .o_st(p_st[s+1]), .o_neg(p_neg[s+1]),
            .o_num(p_num[s+1]), .o_den(p_den[s+1]), .o_rem(p_rem[s+1]), .o_quo(p_quo[s+1])
         );
      end
   endgenerate

   logic [NUM_W-1:0] signed_res;
   assign signed_res = p_neg[NUM_W] ? (~p_quo[NUM_W] + NUM_W'(1)) : p_quo[NUM_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_start <= 1'b0;
      end else begin
         out_valid <= p_vld[NUM_W];
         out_start <= p_st[NUM_W];
      end
   end

   always_ff @(posedge clk) begin
      out_coef <= signed_res[COEF_W-1:0];
   end
endmodule

// File: rtl/coef_quant_chk.sv
module coef_quant_chk #(
   parameter int unsigned COEF_W = 12,
   parameter int unsigned LAT    = 14
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_start,
   input logic [COEF_W-1:0] in_coef,
   input logic              out_valid,
   input logic              out_start,
   input logic [COEF_W-1:0] out_coef
);
   logic [LAT:0] vd, sd, zd, nd;

   always_ff @(posedge clk) begin
      if (rst) begin
         vd <= '0; sd <= '0; zd <= '0; nd <= '0;
      end else begin
         vd <= {vd[LAT-1:0], in_valid};
         sd <= {sd[LAT-1:0], in_valid && in_start};
         zd <= {zd[LAT-1:0], in_valid && (in_coef == '0)};
         nd <= {nd[LAT-1:0], in_valid && in_coef[COEF_W-1]};
      end
   end

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
      out_valid == vd[LAT]); // R5
   AST_START_DELAY: assert property (@(posedge clk) disable iff (rst)
      out_start == sd[LAT]); // R6
   AST_START_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
      out_start |-> out_valid); // R6
   AST_ZERO_STAYS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (out_valid && zd[LAT]) |-> (out_coef == '0)); // R2
   AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
      (out_valid && nd[LAT]) |-> (out_coef[COEF_W-1] || out_coef == '0)); // R2
   AST_POSITIVE_KEPT: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !nd[LAT]) |-> !out_coef[COEF_W-1]); // R2
endmodule

bind coef_quant coef_quant_chk #(.COEF_W(COEF_W), .LAT(LAT)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start), .in_coef(in_coef),
   .out_valid(out_valid), .out_start(out_start), .out_coef(out_coef)
);

// File: tb/test_coef_quant.sv
module test_coef_quant;
   localparam int LATENCY = 14;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tbl_wr_en = 1'b0;
   logic [5:0] tbl_wr_addr = '0;
   logic [7:0] tbl_wr_data = '0;
   logic in_valid = 1'b0;
   logic in_start = 1'b0;
   logic [11:0] in_coef = '0;
   logic out_valid, out_start;
   logic [11:0] out_coef;

   always #5 clk = ~clk;

   coef_quant i_coef_quant (
      .clk(clk), .rst(rst), .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
      .tbl_wr_data(tbl_wr_data), .in_valid(in_valid), .in_start(in_start),
      .in_coef(in_coef), .out_valid(out_valid), .out_start(out_start), .out_coef(out_coef)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit finished = 0;
   int tbl [64];
   int tb_pos = 0;
   int    q_val[$], q_cyc[$];
   bit    q_st[$];
   string q_tag[$];
   int lcg = 32'h1234_5678;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int ref_q(input int x, input int q);
      int qe = (q == 0) ? 1 : q;
      int m = (x < 0) ? -x : x;
      int r = m / qe;
      if (2 * (m % qe) >= qe) r++;
      return (x < 0) ? -r : r;
   endfunction

   task automatic step(input bit v, input bit st, input int coef,
                       input bit we, input int wa, input int wd, input string tag);
      bit busy;
      int p;
      @(negedge clk);
      busy = v || (tb_pos != 0);
      in_valid = v; in_start = st; in_coef = 12'(coef);
      tbl_wr_en = we; tbl_wr_addr = 6'(wa); tbl_wr_data = 8'(wd);
      if (v) begin
         p = st ? 0 : tb_pos;
         tb_pos = (p + 1) % 64;
         q_val.push_back(ref_q(coef, tbl[p]));
         q_st.push_back(st);
         q_cyc.push_back(cyc + 1);
         q_tag.push_back((tbl[p] == 0) ? "R4" : tag);
      end
      if (we && !busy) tbl[wa] = wd;
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, "");
   endtask

   always @(posedge clk) begin
      #2;
      if (!rst && out_valid) begin
         if (q_val.size() == 0) check(0, "R5 unexpected out_valid", 1, 0);
         else begin
            int ev, ec; bit es; string et;
            ev = q_val.pop_front(); ec = q_cyc.pop_front();
            es = q_st.pop_front(); et = q_tag.pop_front();
            check($signed(out_coef) == ev, et, $signed(out_coef), ev);
            check(out_start == es, "R6 out_start", out_start, es);
            check(cyc - ec == LATENCY, "R5 latency", cyc - ec, LATENCY);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;
      check(out_valid == 0, "R8 out_valid after reset", out_valid, 0);
      check(out_start == 0, "R8 out_start after reset", out_start, 0);
      // R1: load table with LCG values; entry 0 = 1, entry 5 = 0 (R4), entry 2 = 2
      for (int a = 0; a < 64; a++) begin
         lcg = lcg * 1103515245 + 12345;
         step(0, 0, 0, 1, a, (a == 0) ? 1 : (a == 5) ? 0 : (a == 2) ? 2 : ((lcg >>> 16) & 255), "R1");
      end
      // R8: first sample without start uses entry 0
      step(1, 0, -7, 0, 0, 0, "R8");
      for (int i = 1; i < 64; i++) step(1, 0, i * 31 - 900, 0, 0, 0, "R3");
      // R2: every input code, block-aligned, with bubbles mid-block
      for (int b = 0; b < 64; b++)
         for (int i = 0; i < 64; i++) begin
            if (((b * 64 + i) % 9) == 4) idle();
            step(1, i == 0, b * 64 + i - 2048, 0, 0, 0, "R2");
         end
      // R1: accepted write at boundary, then used
      step(0, 0, 0, 1, 7, 3, "R1");
      for (int i = 0; i < 64; i++) step(1, i == 0, (i == 7) ? 10 : i * 5, 0, 0, 0, (i == 7) ? "R1" : "R2");
      // R7: writes mid-block and with a sample present are ignored
      for (int i = 0; i < 5; i++) step(1, i == 0, i, 0, 0, 0, "R3");
      step(0, 0, 0, 1, 9, 77, "R7");
      step(1, 0, 100, 1, 10, 1, "R7");
      for (int i = 6; i < 64; i++) step(1, 0, (i == 9 || i == 10) ? 1000 : -i, 0, 0, 0, (i == 9 || i == 10) ? "R7" : "R3");
      for (int i = 0; i < 64; i++) step(1, i == 0, (i == 9 || i == 10) ? -1000 : i, 0, 0, 0, (i == 9 || i == 10) ? "R7" : "R3");
      // R3: wrap without start, then mid-block restart
      for (int i = 0; i < 130; i++) step(1, i == 0, 1500 - i * 23, 0, 0, 0, "R3");
      for (int i = 0; i < 20; i++) step(1, i == 12, 400 - i * 41, 0, 0, 0, "R3");
      for (int i = 0; i < LATENCY + 6; i++) idle();
      check(q_val.size() == 0, "R5 outputs missing", q_val.size(), 0);
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule